// File: doc/BRIEF.md
# Five-Input Prioritized Interrupt Unit

This unit sits beside the core of an 8-bit CPU and decides which interrupt request the core should take next. It takes five request lines. The first is a non-maskable line. Next come three maskable lines, each with a fixed vector: one edge-captured line and two level lines. The last is a general request whose vector comes from outside the block. The unit holds the global enable flag, the three mask bits, the latch for the edge line and the serial output bit.

The core drives a set-mask write to update the masks, drop a captured edge or load the serial output. Each of these actions has its own enable bit in the written byte. A read-mask status word gives the core the global enable, the masks, the pending lines and the synchronized serial input. At every instruction boundary the core may take the winning request. Taking a request clears the global enable. It also consumes the non-maskable edge or the edge latch when that source is the one taken. The stack push and the fetch of the external vector belong to the core.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset the three mask bits read 1 (status bits 2..0 = 111), the global enable reads 0 (status bit 3), the serial output is 0 and no request is presented.
- R2: A pulse on gie_set_i sets the global enable and a pulse on gie_clr_i clears it; if both pulse together, clear wins. While the global enable is 0, none of the four maskable or external sources can win.
- R3: The non-maskable line ignores both the global enable and the masks. It is recognized only on a rising edge and stays requested only while its level is held high. Once taken, it does not request again until a new rising edge.
- R4: A rising edge on the edge line sets a pending latch that stays set after the line falls. The latch shows in status bit 6 whether or not that source is masked.
- R5: Status bits 4 (low level line) and 5 (high level line) follow the synchronized line levels. A level line requests only while it is high, unmasked and globally enabled.
- R6: Priority from high to low is: non-maskable, edge, high level, low level, external. req_src_o is one-hot with bit 4 = non-maskable, bit 3 = edge, bit 2 = high level, bit 1 = low level, bit 0 = external. The vectors are 0x24, 0x3C, 0x34 and 0x2C for the first four sources.
- R7: A set-mask write loads written bits 2..0 into the masks (bit 0 low level, bit 1 high level, bit 2 edge) only when written bit 3 is 1. Otherwise the masks are left as they are.
- R8: A set-mask write with bit 4 set clears the edge latch without the request being taken.
- R9: A set-mask write with bit 6 set loads written bit 7 into ser_out_o. Otherwise ser_out_o holds its value.
- R10: Status bit 7 shows the synchronized serial input.
- R11: When boundary_i is high while a request is presented, the global enable clears on the next clock edge. If the winner is the non-maskable line or the edge latch, that pending state clears too.
- R12: When the external request wins, req_src_o is 00001 and req_vec_o is 0.
- R13: Every input line and the serial input pass through SYNC_STAGES flip-flops before they are used. A change becomes visible in the status word SYNC_STAGES clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request line |
| edge_irq_i | input | 1 | Edge-captured maskable request |
| lvl_hi_i | input | 1 | Higher-priority level request |
| lvl_lo_i | input | 1 | Lower-priority level request |
| ext_irq_i | input | 1 | General request with external vector |
| ser_in_i | input | 1 | Serial input pin |
| gie_set_i | input | 1 | Enable instruction executed |
| gie_clr_i | input | 1 | Disable instruction executed |
| mask_wr_i | input | 1 | Set-mask write strobe |
| mask_wdata_i | input | 8 | Set-mask write byte |
| boundary_i | input | 1 | Instruction boundary; core takes the winner |
| stat_rdata_o | output | 8 | Read-mask status word |
| ser_out_o | output | 1 | Serial output pin |
| req_valid_o | output | 1 | A request is presented |
| req_src_o | output | 5 | One-hot winning source |
| req_vec_o | output | VEC_W | Vector address of the winner |

## Verification
The bench builds the unit with its defaults: SYNC_STAGES = 2 and VEC_W = 16. Two synchronizer stages put the non-maskable and edge recognition three edges behind the pins. The bench therefore lets each stimulus settle before it samples, and it steps the serial input one edge at a time to pin down the exact latency. The 16-bit vector width lets the bench compare all four fixed vectors and the zero external vector in full.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_N = 5;
  // one-hot source index, highest priority highest
  localparam int unsigned SRC_NMI  = 4;
  localparam int unsigned SRC_EDGE = 3;
  localparam int unsigned SRC_HI   = 2;
  localparam int unsigned SRC_LO   = 1;
  localparam int unsigned SRC_EXT  = 0;
  // set-mask write byte fields
  localparam int unsigned MW_MSK_EN = 3;
  localparam int unsigned MW_CLR_E  = 4;
  localparam int unsigned MW_SO_EN  = 6;
  localparam int unsigned MW_SO_D   = 7;
  typedef struct packed {
    logic       gie;
    logic [2:0] msk;
    logic       sod;
  } ctrl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_s_i,
  input  logic edge_s_i,
  input  logic take_nmi_i,
  input  logic take_edge_i,
  input  logic clr_edge_i,
  output logic nmi_req_o,
  output logic edge_pend_o
);
  logic nmi_d, edge_d, nmi_pend, edge_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d     <= 1'b0;
      edge_d    <= 1'b0;
      nmi_pend  <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      nmi_d  <= nmi_s_i;
      edge_d <= edge_s_i;
      if (!nmi_s_i)                nmi_pend <= 1'b0;
      else if (!nmi_d)             nmi_pend <= 1'b1;
      else if (take_nmi_i)         nmi_pend <= 1'b0;
      // a fresh edge beats a same-cycle clear so it is never lost
      if (edge_s_i && !edge_d)     edge_pend <= 1'b1;
      else if (take_edge_i || clr_edge_i) edge_pend <= 1'b0;
    end
  end

  assign nmi_req_o   = nmi_pend & nmi_s_i;
  assign edge_pend_o = edge_pend;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gie_set_i,
  input  logic       gie_clr_i,
  input  logic       take_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);
  ctrl_t r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r.gie <= 1'b0;
      r.msk <= 3'b111;
      r.sod <= 1'b0;
    end else begin
      if (gie_clr_i || take_i) r.gie <= 1'b0;
      else if (gie_set_i)      r.gie <= 1'b1;
      if (wr_i && wdata_i[MW_MSK_EN]) r.msk <= wdata_i[2:0];
      if (wr_i && wdata_i[MW_SO_EN])  r.sod <= wdata_i[MW_SO_D];
    end
  end

  assign ctrl_o = r;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N     = 5,
  parameter int unsigned VEC_W = 16,
  parameter logic [N*VEC_W-1:0] VEC_TAB = '0
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) vec_o = vec_o | VEC_TAB[i*VEC_W +: VEC_W];
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W       = 16,
  parameter logic [VEC_W-1:0] VEC_NMI  = 'h24,
  parameter logic [VEC_W-1:0] VEC_EDGE = 'h3C,
  parameter logic [VEC_W-1:0] VEC_HI   = 'h34,
  parameter logic [VEC_W-1:0] VEC_LO   = 'h2C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             edge_irq_i,
  input  logic             lvl_hi_i,
  input  logic             lvl_lo_i,
  input  logic             ext_irq_i,
  input  logic             ser_in_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_wdata_i,
  input  logic             boundary_i,
  output logic [7:0]       stat_rdata_o,
  output logic             ser_out_o,
  output logic             req_valid_o,
  output logic [4:0]       req_src_o,
  output logic [VEC_W-1:0] req_vec_o
);
  localparam logic [VEC_W-1:0] VEC_EXT = '0;
  localparam logic [SRC_N*VEC_W-1:0] VEC_TAB = {VEC_NMI, VEC_EDGE, VEC_HI, VEC_LO, VEC_EXT};

  logic [5:0] raw, syn;
  logic       nmi_s, edge_s, hi_s, lo_s, ext_s, sin_s;
  logic       nmi_req, edge_pend, take;
  logic [SRC_N-1:0] req, grant;
  ctrl_t      ctrl;
  logic       unused_wbit;

  assign unused_wbit = mask_wdata_i[5];

  assign raw = {ser_in_i, ext_irq_i, lvl_lo_i, lvl_hi_i, edge_irq_i, nmi_i};

  irq_sync #(.W(6), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {sin_s, ext_s, lo_s, hi_s, edge_s, nmi_s} = syn;

  assign take = boundary_i & req_valid_o;

  irq_capture u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nmi_s_i(nmi_s), .edge_s_i(edge_s),
    .take_nmi_i(take & grant[SRC_NMI]),
    .take_edge_i(take & grant[SRC_EDGE]),
    .clr_edge_i(mask_wr_i & mask_wdata_i[MW_CLR_E]),
    .nmi_req_o(nmi_req), .edge_pend_o(edge_pend)
  );

  irq_ctrl_regs u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .take_i(take),
    .wr_i(mask_wr_i), .wdata_i(mask_wdata_i), .ctrl_o(ctrl)
  );

  always_comb begin
    req           = '0;
    req[SRC_NMI]  = nmi_req;
    req[SRC_EDGE] = ctrl.gie & edge_pend & ~ctrl.msk[2];
    req[SRC_HI]   = ctrl.gie & hi_s & ~ctrl.msk[1];
    req[SRC_LO]   = ctrl.gie & lo_s & ~ctrl.msk[0];
    req[SRC_EXT]  = ctrl.gie & ext_s;
  end

  irq_arbiter #(.N(SRC_N), .VEC_W(VEC_W), .VEC_TAB(VEC_TAB)) u_arb (
    .req_i(req), .valid_o(req_valid_o), .grant_o(grant), .vec_o(req_vec_o)
  );

  assign req_src_o    = grant;
  assign ser_out_o    = ctrl.sod;
  assign stat_rdata_o = {sin_s, edge_pend, hi_s, lo_s, ctrl.gie, ctrl.msk};
endmodule

// File: rtl/irq_prio_checks.sv
module irq_prio_checks #(
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 'h24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic             mask_wr_i,
  input logic             msk_en_i,
  input logic             so_en_i,
  input logic [7:0]       stat_rdata_o,
  input logic             ser_out_o,
  input logic             req_valid_o,
  input logic [4:0]       req_src_o,
  input logic [VEC_W-1:0] req_vec_o
);
  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_src_o) && (req_valid_o == (req_src_o != 5'b0))); // R6
  AST_GIE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rdata_o[3] |-> (req_src_o[3:0] == 4'b0)); // R2
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && req_valid_o |=> !stat_rdata_o[3]); // R11
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && msk_en_i) |=> $stable(stat_rdata_o[2:0])); // R7
  AST_SER_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && so_en_i) |=> $stable(ser_out_o)); // R9
  AST_NMI_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_src_o[4] |-> (req_vec_o == VEC_NMI)); // R6
endmodule

bind irq_prio_unit irq_prio_checks #(.VEC_W(VEC_W), .VEC_NMI(VEC_NMI)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i),
  .mask_wr_i(mask_wr_i), .msk_en_i(mask_wdata_i[3]), .so_en_i(mask_wdata_i[6]),
  .stat_rdata_o(stat_rdata_o), .ser_out_o(ser_out_o), .req_valid_o(req_valid_o),
  .req_src_o(req_src_o), .req_vec_o(req_vec_o)
);

// File: tb/sim_irq_prio_unit.sv
`timescale 1ns/1ps
module sim_irq_prio_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, edg = 0, hi = 0, lo = 0, ext = 0, sin = 0;
  logic gset = 0, gclr = 0, mwr = 0, bnd = 0;
  logic [7:0] mwd = 0;
  logic [7:0] stat;
  logic sout, rv;
  logic [4:0] src;
  logic [15:0] vec;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_prio_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .edge_irq_i(edg), .lvl_hi_i(hi),
    .lvl_lo_i(lo), .ext_irq_i(ext), .ser_in_i(sin), .gie_set_i(gset),
    .gie_clr_i(gclr), .mask_wr_i(mwr), .mask_wdata_i(mwd), .boundary_i(bnd),
    .stat_rdata_o(stat), .ser_out_o(sout), .req_valid_o(rv), .req_src_o(src),
    .req_vec_o(vec)
  );

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic wr_mask(logic [7:0] d);
    mwr = 1; mwd = d; @(negedge clk); mwr = 0; mwd = 0;
  endtask
  task automatic gie_on();  gset = 1; @(negedge clk); gset = 0; endtask
  task automatic gie_off(); gclr = 1; @(negedge clk); gclr = 0; endtask
  task automatic take();    bnd = 1;  @(negedge clk); bnd = 0;  endtask

  task automatic t_reset();
    chk("R1 status", stat, 8'h07);
    chk("R1 ser_out", sout, 0);
    chk("R1 valid", rv, 0);
  endtask

  task automatic t_gie();
    gie_on();
    chk("R2 set", stat[3], 1);
    gset = 1; gclr = 1; @(negedge clk); gset = 0; gclr = 0;
    chk("R2 clr wins", stat[3], 0);
  endtask

  task automatic t_nmi();
    nmi = 1; settle();
    chk("R3 nmi ungated src", src, 5'b10000);
    chk("R6 nmi vec", vec, 16'h24);
    take();
    chk("R11 nmi consumed", rv, 0);
    nmi = 0; settle(); nmi = 1; settle();
    chk("R3 new edge", rv, 1);
    nmi = 0; settle();
    chk("R3 level dropped", rv, 0);
  endtask

  task automatic t_edge();
    edg = 1; @(negedge clk); edg = 0; settle();
    chk("R4 pending held", stat[6], 1);
    chk("R4 masked no req", rv, 0);
    wr_mask(8'h08); gie_on();
    chk("R6 edge src", src, 5'b01000);
    chk("R6 edge vec", vec, 16'h3C);
    wr_mask(8'h10);
    chk("R8 latch cleared", stat[6], 0);
    chk("R8 no req", rv, 0);
    edg = 1; @(negedge clk); edg = 0; settle();
    take();
    chk("R11 latch consumed", stat[6], 0);
    chk("R11 gie cleared", stat[3], 0);
  endtask

  task automatic t_level();
    gie_on(); hi = 1; lo = 1; settle();
    chk("R5 pending bits", stat[5:4], 2'b11);
    chk("R6 hi src", src, 5'b00100);
    chk("R6 hi vec", vec, 16'h34);
    hi = 0; settle();
    chk("R6 lo src", src, 5'b00010);
    chk("R6 lo vec", vec, 16'h2C);
    lo = 0; ext = 1; settle();
    chk("R12 ext src", src, 5'b00001);
    chk("R12 ext vec", vec, 16'h0);
    ext = 0;
    wr_mask(8'h07);
    chk("R7 no load", stat[2:0], 3'b000);
    wr_mask(8'h0F);
    chk("R7 load", stat[2:0], 3'b111);
    lo = 1; settle();
    chk("R5 masked level", rv, 0);
    lo = 0; gie_off(); settle();
  endtask

  task automatic t_prio();
    wr_mask(8'h08); gie_on();
    nmi = 1; hi = 1; lo = 1; ext = 1; edg = 1; settle();
    chk("R6 nmi wins", src, 5'b10000);
    take();
    chk("R11 gie off blocks", rv, 0);
    gie_on();
    chk("R6 edge over levels", src, 5'b01000);
    nmi = 0; hi = 0; lo = 0; ext = 0; edg = 0;
    wr_mask(8'h10); gie_off(); settle();
  endtask

  task automatic t_serial();
    wr_mask(8'hC0);
    chk("R9 load 1", sout, 1);
    wr_mask(8'h80);
    chk("R9 no enable", sout, 1);
    wr_mask(8'h40);
    chk("R9 load 0", sout, 0);
    sin = 1; @(negedge clk);
    chk("R13 one edge", stat[7], 0);
    @(negedge clk);
    chk("R13 two edges", stat[7], 1);
    chk("R10 serial in", stat[7], sin);
    sin = 0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset(); t_gie(); t_nmi(); t_edge(); t_level(); t_prio(); t_serial();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule